// File: doc/BRIEF.md
# Sequential Floating-Point Normalize-and-Round Unit

This block is the last stage behind an iterative adder or divider. It takes an unrounded single-precision result and returns the packed 32-bit word. In add mode the result arrives as a sign, a biased exponent and a 28-bit sum word that may hold a carry bit above the hidden bit. In divide mode the result arrives as a 27-bit quotient and the divider's remainder. Three bits are kept below the mantissa: guard, round and sticky. The sticky bit stays exact, so nothing below the round position is ever lost.

A small state machine does the work one step per clock. It loads and splits the input, then shifts one bit per cycle until the result is normal or has reached the smallest normal exponent. It then rounds to nearest with ties to even, corrects a carry that rounding produces, packs the word and pulses `outDone`. Only one operation is in flight at a time. `inReady` tells the producer when a new operand may be offered.

Top module: `fpNormRound`

## Requirements
- R1: `inReady` is high only while the unit is idle, including right after reset. An operand is taken on a rising edge where `inValid` and `inReady` are both high. From that edge until the cycle after the done pulse, `inReady` is low, and any values on the input pins have no effect on the result.
- R2: `outDone` is high for exactly one cycle per accepted operand, and `outWord` holds its value until the next result. If no normalization shift is needed, `outDone` is high in the cycle that follows the fifth rising edge after the accepting edge. Reset clears `outWord` to 0 and `outDone` to 0.
- R3: In add mode (`inMode` = 0) with `inSum[27]` = 0, the mantissa is `inSum[26:3]`, guard is `inSum[2]`, round is `inSum[1]`, sticky is `inSum[0]`, and the exponent is `inExp`.
- R4: In add mode with `inSum[27]` = 1, the mantissa is `inSum[27:4]`, guard is `inSum[3]`, round is `inSum[2]`, sticky is `inSum[1]` OR `inSum[0]`, and the exponent is `inExp` + 1.
- R5: In divide mode (`inMode` = 1), the mantissa is `inQuot[26:3]`, guard is `inQuot[2]` and round is `inQuot[1]`. Sticky is `inQuot[0]` OR (`inRem` != 0), so a non-zero remainder always counts as a discarded part.
- R6: While the exponent is below 1, each cycle shifts the mantissa right by one bit and adds 1 to the exponent. Guard takes the old mantissa LSB, round takes the old guard, and sticky becomes old round OR old sticky. The result is a subnormal with exponent field 0.
- R7: While the hidden bit (mantissa bit 23) is 0 and the exponent is above 1, each cycle shifts left by one bit and subtracts 1 from the exponent. Guard enters the mantissa LSB, round moves into guard, 0 enters round, and sticky is kept. An all-zero input gives a signed zero.
- R8: Rounding is to nearest, ties to even. One unit is added to the mantissa when guard is 1 and at least one of round, sticky or the mantissa LSB is 1. Otherwise the mantissa is truncated.
- R9: If rounding carries out of the 24-bit mantissa, the mantissa is halved and the exponent incremented. An exponent of 255 or more packs as infinity with the operand's sign (exponent field all ones, fraction 0).
- R10: `outWord` is {sign, exponent field, fraction}. The sign is in bit 31, the exponent field in bits 30:23 and the fraction in bits 22:0. The exponent field is 0 when the hidden bit of the final mantissa is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer offers an operand |
| inReady | output | 1 | Unit is idle and takes the operand |
| inMode | input | 1 | 0 = add (use inSum), 1 = divide (use inQuot, inRem) |
| inSign | input | 1 | Sign of the result |
| inExp | input | 10 | Biased exponent, two's complement, may be below 1 |
| inSum | input | 28 | Adder sum word: carry, hidden bit, 23 fraction bits, guard, round, sticky |
| inQuot | input | 27 | Divider quotient: 24 mantissa bits then guard, round, sticky |
| inRem | input | 26 | Divider remainder; only zero versus non-zero matters |
| outWord | output | 32 | Packed single-precision result |
| outDone | output | 1 | One-cycle pulse when outWord holds a new result |

## Verification
The latency depends on how many shift steps the operand needs. The bench therefore waits for `outDone`, sampling on the falling edge, and compares `outWord` in that same cycle against an exact integer rounding model. For an operand that needs no shift, the bench also checks that `outDone` first appears on the sixth falling edge after the accepting rising edge, which is five register stages later. It also checks that `outDone` is low again one falling edge later while `outWord` stays the same. Inputs offered while the unit is busy are held for several cycles, and the bench confirms they change neither the pending result nor the cycles that follow.

// File: rtl/fnr_pkg.sv
package fnr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_NORM,
    ST_ROUND,
    ST_CORR,
    ST_PACK,
    ST_DONE
  } fnrState_t;

  // One strobe per datapath action; at most one is high in any cycle.
  typedef struct packed {
    logic capture;
    logic load;
    logic shiftR;
    logic shiftL;
    logic roundStep;
    logic correct;
    logic pack;
  } fnrCtl_t;

endpackage

// File: rtl/fnr_datapath.sv
module fnr_datapath
  import fnr_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 8,
  parameter int REM_W  = 26
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fnrCtl_t                   ctl,
  input  logic                      inMode,
  input  logic                      inSign,
  input  logic [EXP_W+1:0]          inExp,
  input  logic [MANT_W+3:0]         inSum,
  input  logic [MANT_W+2:0]         inQuot,
  input  logic [REM_W-1:0]          inRem,
  output logic                      needRight,
  output logic                      needLeft,
  output logic [EXP_W+MANT_W-1:0]   outWord
);

  localparam int SUM_W  = MANT_W + 4;
  localparam int QUOT_W = MANT_W + 3;
  localparam int EXPI_W = EXP_W + 2;
  localparam int WORD_W = EXP_W + MANT_W;
  localparam logic signed [EXPI_W-1:0] ONE_E   = EXPI_W'(1);
  localparam logic signed [EXPI_W-1:0] EXP_TOP = EXPI_W'((1 << EXP_W) - 1);

  // Captured operand
  logic                     rawMode;
  logic                     rawSign;
  logic signed [EXPI_W-1:0] rawExp;
  logic [SUM_W-1:0]         rawSum;
  logic [QUOT_W-1:0]        rawQuot;
  logic [REM_W-1:0]         rawRem;

  // Working state: mantissa has one spare bit on top for the rounding carry
  logic                     sign;
  logic signed [EXPI_W-1:0] exp;
  logic [MANT_W:0]          mant;
  logic                     guardB;
  logic                     roundB;
  logic                     stickyB;

  logic                     rndInc;
  logic                     isInf;
  logic [EXP_W-1:0]         expField;

  assign rndInc    = guardB & (roundB | stickyB | mant[0]);
  assign needRight = exp < ONE_E;
  assign needLeft  = !mant[MANT_W-1] && (exp > ONE_E);
  assign isInf     = exp >= EXP_TOP;
  assign expField  = mant[MANT_W-1] ? exp[EXP_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawMode <= 1'b0;
      rawSign <= 1'b0;
      rawExp  <= '0;
      rawSum  <= '0;
      rawQuot <= '0;
      rawRem  <= '0;
    end else if (ctl.capture) begin
      rawMode <= inMode;
      rawSign <= inSign;
      rawExp  <= inExp;
      rawSum  <= inSum;
      rawQuot <= inQuot;
      rawRem  <= inRem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sign    <= 1'b0;
      exp     <= '0;
      mant    <= '0;
      guardB  <= 1'b0;
      roundB  <= 1'b0;
      stickyB <= 1'b0;
      outWord <= '0;
    end else if (ctl.load) begin
      sign <= rawSign;
      if (rawMode) begin
        mant    <= {1'b0, rawQuot[QUOT_W-1:3]};
        guardB  <= rawQuot[2];
        roundB  <= rawQuot[1];
        stickyB <= rawQuot[0] | (rawRem != '0);
        exp     <= rawExp;
      end else if (rawSum[SUM_W-1]) begin
        mant    <= {1'b0, rawSum[SUM_W-1:4]};
        guardB  <= rawSum[3];
        roundB  <= rawSum[2];
        stickyB <= rawSum[1] | rawSum[0];
        exp     <= rawExp + ONE_E;
      end else begin
        mant    <= {1'b0, rawSum[SUM_W-2:3]};
        guardB  <= rawSum[2];
        roundB  <= rawSum[1];
        stickyB <= rawSum[0];
        exp     <= rawExp;
      end
    end else if (ctl.shiftR) begin
      mant    <= mant >> 1;
      guardB  <= mant[0];
      roundB  <= guardB;
      stickyB <= roundB | stickyB;
      exp     <= exp + ONE_E;
    end else if (ctl.shiftL) begin
      mant    <= {1'b0, mant[MANT_W-2:0], guardB};
      guardB  <= roundB;
      roundB  <= 1'b0;
      exp     <= exp - ONE_E;
    end else if (ctl.roundStep) begin
      mant <= mant + (MANT_W+1)'(rndInc);
    end else if (ctl.correct) begin
      if (mant[MANT_W]) begin
        mant <= mant >> 1;
        exp  <= exp + ONE_E;
      end
    end else if (ctl.pack) begin
      if (isInf)
        outWord <= {sign, {EXP_W{1'b1}}, {(MANT_W-1){1'b0}}};
      else
        outWord <= {sign, expField, mant[MANT_W-2:0]};
    end
  end

  AST_RSHIFT_EXP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftR |=> exp == $past(exp) + ONE_E); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftR || ctl.shiftL) && stickyB |=> stickyB); // R6
  AST_NORM_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.roundStep |-> (exp >= ONE_E) && (mant[MANT_W-1] || exp == ONE_E)); // R7
  AST_CORR_FITS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.correct |=> !mant[MANT_W]); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.pack |=> $stable(outWord)); // R2

  logic unusedWidth;
  assign unusedWidth = ^WORD_W;

endmodule

// File: rtl/fnr_control.sv
module fnr_control
  import fnr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    needRight,
  input  logic    needLeft,
  output logic    inReady,
  output logic    outDone,
  output fnrCtl_t ctl
);

  fnrState_t state;
  fnrState_t stateNext;

  assign inReady = (state == ST_IDLE);
  assign outDone = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        ctl.capture = 1'b1;
        stateNext   = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.load  = 1'b1;
        stateNext = ST_NORM;
      end
      ST_NORM: begin
        if (needRight)     ctl.shiftR = 1'b1;
        else if (needLeft) ctl.shiftL = 1'b1;
        else               stateNext  = ST_ROUND;
      end
      ST_ROUND: begin
        ctl.roundStep = 1'b1;
        stateNext     = ST_CORR;
      end
      ST_CORR: begin
        ctl.correct = 1'b1;
        stateNext   = ST_PACK;
      end
      ST_PACK: begin
        ctl.pack  = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone); // R2
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl)); // R7
  AST_DONE_AFTER_PACK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pack |=> outDone); // R2

endmodule

// File: rtl/fpNormRound.sv
module fpNormRound
  import fnr_pkg::*;
#(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 8,
  parameter int REM_W  = 26
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic                    inMode,
  input  logic                    inSign,
  input  logic [EXP_W+1:0]        inExp,
  input  logic [MANT_W+3:0]       inSum,
  input  logic [MANT_W+2:0]       inQuot,
  input  logic [REM_W-1:0]        inRem,
  output logic [EXP_W+MANT_W-1:0] outWord,
  output logic                    outDone
);

  fnrCtl_t ctl;
  logic    needRight;
  logic    needLeft;

  fnr_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .needRight(needRight),
    .needLeft (needLeft),
    .inReady  (inReady),
    .outDone  (outDone),
    .ctl      (ctl)
  );

  fnr_datapath #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W),
    .REM_W (REM_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inMode   (inMode),
    .inSign   (inSign),
    .inExp    (inExp),
    .inSum    (inSum),
    .inQuot   (inQuot),
    .inRem    (inRem),
    .needRight(needRight),
    .needLeft (needLeft),
    .outWord  (outWord)
  );

endmodule

// File: tb/fpNormRound_test.sv
`timescale 1ns/1ps
module fpNormRound_test;

  typedef struct packed {
    logic        mode;
    logic        sign;
    logic [9:0]  exp;
    logic [27:0] sum;
    logic [26:0] quot;
    logic [25:0] rem;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b0, 1'b0, 10'd127,  28'h4000000, 27'h0,       26'h0}, // R3 exact
    '{1'b0, 1'b0, 10'd127,  28'h4000003, 27'h0,       26'h0}, // R8 below half
    '{1'b0, 1'b0, 10'd127,  28'h4000004, 27'h0,       26'h0}, // R8 tie even
    '{1'b0, 1'b1, 10'd127,  28'h400000C, 27'h0,       26'h0}, // R8 tie odd
    '{1'b0, 1'b0, 10'd130,  28'h4000005, 27'h0,       26'h0}, // R8 above half
    '{1'b0, 1'b0, 10'd127,  28'h8000018, 27'h0,       26'h0}, // R4 carry tie odd
    '{1'b0, 1'b0, 10'd127,  28'h8000009, 27'h0,       26'h0}, // R4 sticky from bit0
    '{1'b0, 1'b0, 10'd127,  28'h7FFFFFC, 27'h0,       26'h0}, // R9 carry on round
    '{1'b0, 1'b1, 10'd254,  28'h7FFFFFC, 27'h0,       26'h0}, // R9 infinity
    '{1'b0, 1'b0, 10'd127,  28'h0000100, 27'h0,       26'h0}, // R7 left shifts
    '{1'b0, 1'b0, 10'd3,    28'h0001000, 27'h0,       26'h0}, // R7 stop at min exp
    '{1'b0, 1'b1, 10'd100,  28'h0000000, 27'h0,       26'h0}, // R7 signed zero
    '{1'b0, 1'b0, 10'h3FD,  28'h4000005, 27'h0,       26'h0}, // R6 subnormal
    '{1'b0, 1'b0, 10'h3EA,  28'h7FFFFFF, 27'h0,       26'h0}, // R6 deep shift
    '{1'b1, 1'b0, 10'd127,  28'h0,       27'h4000004, 26'h0}, // R5 tie, no rem
    '{1'b1, 1'b0, 10'd127,  28'h0,       27'h4000004, 26'h1}, // R5 rem sets sticky
    '{1'b1, 1'b0, 10'd127,  28'h0,       27'h2000003, 26'h5}, // R5 one left shift
    '{1'b1, 1'b1, 10'd60,   28'h0,       27'h4000005, 26'h0}, // R5 quot bit0 sticky
    '{1'b1, 1'b0, 10'h3FF,  28'h0,       27'h7FFFFFF, 26'h3}  // R6 divide subnormal
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inMode = 1'b0;
  logic        inSign = 1'b0;
  logic [9:0]  inExp = '0;
  logic [27:0] inSum = '0;
  logic [26:0] inQuot = '0;
  logic [25:0] inRem = '0;
  logic [31:0] outWord;
  logic        outDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpNormRound uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMode(inMode), .inSign(inSign), .inExp(inExp), .inSum(inSum),
    .inQuot(inQuot), .inRem(inRem), .outWord(outWord), .outDone(outDone)
  );

  // Exact integer rounding model built from the requirements
  function automatic logic [31:0] refModel(vec_t v);
    longint unsigned val, m, low, half;
    int hp, p, e, sh;
    logic signed [9:0] ex;
    ex = v.exp;
    if (v.mode) begin
      val = {37'd0, v.quot, (v.rem != 26'd0)};
      hp  = 27;
    end else begin
      val = {36'd0, v.sum};
      hp  = 26;
    end
    if (val == 0) return {v.sign, 31'd0};
    p = 0;
    for (int i = 0; i < 30; i++) if (val[i]) p = i;
    e  = int'(ex) + p - hp;
    sh = p - 23;
    if (e < 1) begin
      sh = sh + (1 - e);
      e  = 1;
    end
    if (sh <= 0) begin
      m = val << (-sh);
    end else if (sh >= 62) begin
      m = 0;
    end else begin
      m    = val >> sh;
      low  = val & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (low > half || (low == half && m[0])) m = m + 1;
    end
    if (m >= 64'd16777216) begin
      m = m >> 1;
      e = e + 1;
    end
    if (e >= 255) return {v.sign, 8'hFF, 23'd0};
    return {v.sign, (m[23] ? e[7:0] : 8'd0), m[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input vec_t v);
    inMode = v.mode;
    inSign = v.sign;
    inExp  = v.exp;
    inSum  = v.sum;
    inQuot = v.quot;
    inRem  = v.rem;
  endtask

  // Called at a falling edge while idle; returns at the falling edge where outDone is high.
  // cycles counts falling edges after the accepting rising edge.
  task automatic runVec(input vec_t v, output logic [31:0] res, output int cycles);
    drive(v);
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    cycles = 1;
    while (!outDone && cycles < 2000) begin
      @(negedge clk);
      cycles++;
    end
    if (!outDone) begin
      checks++;
      errors++;
      $display("FAIL R2 timeout actual=no_done expected=done");
    end
    res = outWord;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] res;
    int cyc;
    vec_t v;
    vec_t other;

    repeat (3) @(negedge clk);
    // R1 / R2: reset state
    check("R1 ready in reset", {31'd0, inReady}, 32'd1);
    check("R2 done low in reset", {31'd0, outDone}, 32'd0);
    check("R2 word cleared", outWord, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, inReady}, 32'd1);

    // R3 / R10: hand value 1.0 and no-shift latency
    runVec(VECS[0], res, cyc);
    check("R10 one point zero", res, 32'h3F800000);
    check("R2 latency", cyc, 6);
    @(negedge clk);
    check("R2 done single cycle", {31'd0, outDone}, 32'd0);
    check("R2 word held", outWord, 32'h3F800000);
    check("R1 ready after done", {31'd0, inReady}, 32'd1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      runVec(VECS[i], res, cyc);
      check($sformatf("table[%0d]", i), res, refModel(VECS[i]));
      @(negedge clk);
    end

    // R5 hand values: remainder decides a tie
    runVec(VECS[14], res, cyc);
    check("R5 tie without rem", res, 32'h3F800000);
    @(negedge clk);
    runVec(VECS[15], res, cyc);
    check("R5 tie with rem", res, 32'h3F800001);
    @(negedge clk);
    // R9 hand value
    runVec(VECS[8], res, cyc);
    check("R9 infinity", res, 32'hFF800000);
    @(negedge clk);

    // R1: inputs offered while busy are ignored
    v = VECS[3];
    other = VECS[13];
    drive(v);
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 not ready while busy", {31'd0, inReady}, 32'd0);
    drive(other);
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    cyc = 0;
    while (!outDone && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check("R1 busy input ignored", outWord, refModel(v));
    begin
      int spurious = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (outDone) spurious++;
      end
      check("R1 no extra operation", spurious, 0);
    end

    // Random add operands (no multi-bit left shifts)
    for (int i = 0; i < 160; i++) begin
      v = '0;
      v.mode = 1'b0;
      v.sign = 1'($urandom);
      v.exp  = 10'(int'($urandom % 240) - 20);
      v.sum  = 28'($urandom);
      if (i % 2 == 0) v.sum[27] = 1'b1;
      else begin
        v.sum[27] = 1'b0;
        v.sum[26] = 1'b1;
      end
      if (i % 5 == 0) v.sum[2:0] = 3'b100;     // R8 ties
      runVec(v, res, cyc);
      check("R3 R4 random add", res, refModel(v));
      @(negedge clk);
    end

    // Random divide operands
    for (int i = 0; i < 160; i++) begin
      v = '0;
      v.mode = 1'b1;
      v.sign = 1'($urandom);
      v.exp  = 10'(int'($urandom % 240) - 20);
      v.quot = 27'($urandom);
      if (i % 3 == 0) v.quot[26:25] = 2'b01;
      else            v.quot[26] = 1'b1;
      v.rem  = (i % 4 == 0) ? 26'd0 : 26'($urandom);
      if (i % 6 == 0) v.quot[2:0] = 3'b100;    // R5 tie settled by remainder
      runVec(v, res, cyc);
      check("R5 random divide", res, refModel(v));
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule